// File: doc/BRIEF.md
# IDE Programmed-I/O Cycle Timer

This block produces the read and write strobes for the programmed-I/O cycles of one IDE channel. When a request is accepted, the strobe for the requested direction goes low. The device ready line is first examined a programmable number of clocks later. If the device holds ready low, the strobe stays low and ready is examined again on every clock. Once ready is seen high, the strobe is released and a one-clock completion pulse is issued. A programmable recovery gap, measured from that final ready sample, then has to expire before another strobe may begin.

Each drive on the channel has its own pair of 2-bit timing codes, a sample-point code and a recovery code. The drive addressed by a request selects which pair applies. Both codes are inverted with an offset: a larger code gives a shorter time. The drive, the direction and the recovery code are captured when the request is accepted. Changes on those inputs while a cycle is under way therefore do not affect that cycle. A request that arrives while the engine is busy simply waits until the engine is idle again.

Top module: `ide_pio_timer`

## Requirements
- R1: While reset is asserted, and after it is released with no request pending, both strobes are high (inactive), busy is low and done is low, whatever the ready line does.
- R2: A request seen while busy is low is accepted on that clock edge. In the next cycle busy is high and exactly one strobe is low: the write strobe when the direction input was 1, the read strobe when it was 0.
- R3: With ready high, the strobe stays low for exactly 5 − c clocks, where c is the addressed drive's sample-point code (00→5, 01→4, 10→3, 11→2 clocks).
- R4: Each clock edge at or after the sample point on which ready is low keeps the strobe low for one more clock. Ready is checked on every clock until it is seen high.
- R5: done is high for exactly one cycle, the cycle after the edge on which ready was seen high. Both strobes are already high in that cycle.
- R6: When a request is pending continuously, the strobe stays high for exactly 4 − r clocks between cycles, counted from the edge on which ready was seen high. Here r is the recovery code of the drive used by the finished cycle (00→4, 01→3, 10→2, 11→1). busy stays high until the last of those clocks.
- R7: Drive d uses bits [2d+1:2d] of both the sample-point code bus and the recovery code bus.
- R8: A request held while a cycle or its recovery is in progress is not accepted before the recovery gap has fully elapsed.
- R9: The drive select, the direction and the recovery code are captured at acceptance. Changing those inputs later does not alter the strobe width, the strobe used, or the recovery gap of the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Cycle request, held until seen accepted |
| req_drive | input | DRV_SEL_W | Drive addressed by the request |
| req_write | input | 1 | Direction: 1 write, 0 read |
| iordy | input | 1 | Device ready line (high = ready) |
| sample_codes | input | NUM_DRIVES*CODE_W | Sample-point code per drive, drive d at bits [2d+1:2d] |
| recov_codes | input | NUM_DRIVES*CODE_W | Recovery code per drive, drive d at bits [2d+1:2d] |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |
| busy | output | 1 | High from acceptance until recovery has elapsed |
| done | output | 1 | One-cycle pulse after ready is seen high |

## Verification
Back-to-back cycles are driven with every sample-point and recovery code, on both drives and in both directions. The bench measures the strobe width and the gap to the next strobe, which tells apart a wrong code decode, a wrong drive's field pair, and a recovery that starts from the strobe edge instead of the ready sample. Some patterns hold ready low for one to three extra clocks, which separates "sample once" from "resample every clock". A separate run changes the drive, direction and codes in the middle of a cycle to show that they were captured at acceptance. Another run asserts reset in the middle of a strobe.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  typedef enum logic [1:0] {
    PIO_IDLE    = 2'd0,
    PIO_STROBE  = 2'd1,
    PIO_RECOVER = 2'd2
  } pio_state_e;

  // Inverted code with offset: the largest code gives the shortest time.
  function automatic int code_to_clocks(input int code, input int longest);
    return longest - code;
  endfunction

endpackage

// File: rtl/pio_reset_sync.sv
module pio_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pio_timing_select.sv
module pio_timing_select #(
  parameter int NUM_DRIVES     = 2,
  parameter int CODE_W         = 2,
  parameter int DRV_SEL_W      = 1,
  parameter int CNT_W          = 3,
  parameter int SAMPLE_LONGEST = 5,
  parameter int RECOV_LONGEST  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         capture,
  input  logic [DRV_SEL_W-1:0]         drive_sel,
  input  logic [NUM_DRIVES*CODE_W-1:0] sample_codes,
  input  logic [NUM_DRIVES*CODE_W-1:0] recov_codes,
  output logic [CNT_W-1:0]             sample_load_clks,
  output logic [CNT_W-1:0]             recov_held_clks
);

  logic [CODE_W-1:0] samp_arr [NUM_DRIVES];
  logic [CODE_W-1:0] rec_arr  [NUM_DRIVES];
  logic [CODE_W-1:0] recov_code_d, recov_code_q;

  // Split the flat buses into per-drive fields (drive d at [d*CODE_W +: CODE_W])
  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_field
    assign samp_arr[g] = sample_codes[g*CODE_W +: CODE_W];
    assign rec_arr[g]  = recov_codes[g*CODE_W +: CODE_W];
  end

  // Sample-point length is consumed at the acceptance edge itself
  assign sample_load_clks =
    CNT_W'(ide_pio_pkg::code_to_clocks(int'(samp_arr[drive_sel]), SAMPLE_LONGEST));

  // Recovery code is used later, so it is captured with a clock enable
  always_comb begin
    recov_code_d = recov_code_q;
    if (capture) recov_code_d = rec_arr[drive_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) recov_code_q <= '0;
    else        recov_code_q <= recov_code_d;
  end

  assign recov_held_clks =
    CNT_W'(ide_pio_pkg::code_to_clocks(int'(recov_code_q), RECOV_LONGEST));

  // R9
  recov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(recov_code_q));

  // R7
  recov_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> recov_code_q == $past(rec_arr[drive_sel]));

endmodule

// File: rtl/pio_interval_counter.sv
module pio_interval_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             is_zero,
  output logic             is_one
);

  logic [CNT_W-1:0] cnt_d, cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                    cnt_d = load_val;
    else if (dec && !is_zero)    cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == CNT_W'(1));

  // R3
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !is_zero) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

endmodule

// File: rtl/pio_cycle_fsm.sv
module pio_cycle_fsm
  import ide_pio_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             iordy,
  input  logic [CNT_W-1:0] sample_load_clks,
  input  logic [CNT_W-1:0] recov_held_clks,
  input  logic             cnt_zero,
  input  logic             cnt_one,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_load_val,
  output logic             cnt_dec,
  output logic             capture,
  output logic             rd_strobe_n,
  output logic             wr_strobe_n,
  output logic             busy,
  output logic             done
);

  pio_state_e state_d, state_q;
  logic       write_d, write_q;
  logic       done_d,  done_q;
  logic       ready_hit;

  assign capture   = (state_q == PIO_IDLE) && req_valid;
  assign ready_hit = (state_q == PIO_STROBE) && cnt_zero && iordy;

  // Next-state and counter control
  always_comb begin
    state_d      = state_q;
    cnt_load     = 1'b0;
    cnt_load_val = '0;
    cnt_dec      = 1'b0;
    case (state_q)
      PIO_IDLE: begin
        if (req_valid) begin
          state_d      = PIO_STROBE;
          cnt_load     = 1'b1;
          cnt_load_val = sample_load_clks - CNT_W'(1);
        end
      end
      PIO_STROBE: begin
        if (!cnt_zero) begin
          cnt_dec = 1'b1;
        end else if (iordy) begin
          if (recov_held_clks > CNT_W'(1)) begin
            state_d      = PIO_RECOVER;
            cnt_load     = 1'b1;
            cnt_load_val = recov_held_clks - CNT_W'(1);
          end else begin
            state_d = PIO_IDLE;
          end
        end
      end
      PIO_RECOVER: begin
        cnt_dec = 1'b1;
        if (cnt_one) state_d = PIO_IDLE;
      end
      default: state_d = PIO_IDLE;
    endcase
  end

  always_comb begin
    write_d = write_q;
    if (capture) write_d = req_write;
    done_d = ready_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PIO_IDLE;
      write_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      write_q <= write_d;
      done_q  <= done_d;
    end
  end

  assign rd_strobe_n = !((state_q == PIO_STROBE) && !write_q);
  assign wr_strobe_n = !((state_q == PIO_STROBE) &&  write_q);
  assign busy        = (state_q != PIO_IDLE);
  assign done        = done_q;

  // R2
  accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PIO_IDLE && req_valid) |=> (busy && (rd_strobe_n != wr_strobe_n)));

  // R4
  ready_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PIO_STROBE && cnt_zero && !iordy) |=> (state_q == PIO_STROBE && $stable(write_q)));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rd_strobe_n && wr_strobe_n));

  // R8
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PIO_RECOVER) |=> (state_q != PIO_STROBE));

endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer #(
  parameter int NUM_DRIVES     = 2,
  parameter int CODE_W         = 2,
  parameter int SAMPLE_LONGEST = 5,
  parameter int RECOV_LONGEST  = 4,
  parameter int RST_STAGES     = 2,
  parameter int DRV_SEL_W      = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1,
  parameter int CNT_W          = $clog2(((SAMPLE_LONGEST > RECOV_LONGEST) ?
                                         SAMPLE_LONGEST : RECOV_LONGEST) + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [DRV_SEL_W-1:0]         req_drive,
  input  logic                         req_write,
  input  logic                         iordy,
  input  logic [NUM_DRIVES*CODE_W-1:0] sample_codes,
  input  logic [NUM_DRIVES*CODE_W-1:0] recov_codes,
  output logic                         rd_strobe_n,
  output logic                         wr_strobe_n,
  output logic                         busy,
  output logic                         done
);

  logic             rst_sync_n;
  logic             capture;
  logic [CNT_W-1:0] sample_load_clks;
  logic [CNT_W-1:0] recov_held_clks;
  logic             cnt_load, cnt_dec, cnt_zero, cnt_one;
  logic [CNT_W-1:0] cnt_load_val;

  pio_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  pio_timing_select #(
    .NUM_DRIVES     (NUM_DRIVES),
    .CODE_W         (CODE_W),
    .DRV_SEL_W      (DRV_SEL_W),
    .CNT_W          (CNT_W),
    .SAMPLE_LONGEST (SAMPLE_LONGEST),
    .RECOV_LONGEST  (RECOV_LONGEST)
  ) u_sel (
    .clk              (clk),
    .rst_n            (rst_sync_n),
    .capture          (capture),
    .drive_sel        (req_drive),
    .sample_codes     (sample_codes),
    .recov_codes      (recov_codes),
    .sample_load_clks (sample_load_clks),
    .recov_held_clks  (recov_held_clks)
  );

  pio_interval_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .dec      (cnt_dec),
    .is_zero  (cnt_zero),
    .is_one   (cnt_one)
  );

  pio_cycle_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk              (clk),
    .rst_n            (rst_sync_n),
    .req_valid        (req_valid),
    .req_write        (req_write),
    .iordy            (iordy),
    .sample_load_clks (sample_load_clks),
    .recov_held_clks  (recov_held_clks),
    .cnt_zero         (cnt_zero),
    .cnt_one          (cnt_one),
    .cnt_load         (cnt_load),
    .cnt_load_val     (cnt_load_val),
    .cnt_dec          (cnt_dec),
    .capture          (capture),
    .rd_strobe_n      (rd_strobe_n),
    .wr_strobe_n      (wr_strobe_n),
    .busy             (busy),
    .done             (done)
  );

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_strobe_n || wr_strobe_n));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> (rd_strobe_n && wr_strobe_n));

endmodule

// File: tb/tb_ide_pio_timer.sv
module tb_ide_pio_timer;

  typedef struct packed {
    logic       drive;
    logic       write;
    logic [1:0] s0;
    logic [1:0] r0;
    logic [1:0] s1;
    logic [1:0] r1;
    logic [3:0] waits;
    logic [3:0] exp_w;
    logic [3:0] exp_gap;
  } vec_t;

  // drive, write, samp0, rec0, samp1, rec1, ready-low clocks, strobe width, gap
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 2'd0, 2'd0, 2'd3, 2'd3, 4'd0, 4'd5, 4'd4},
    '{1'b0, 1'b1, 2'd3, 2'd3, 2'd0, 2'd0, 4'd0, 4'd2, 4'd1},
    '{1'b1, 1'b0, 2'd0, 2'd0, 2'd3, 2'd3, 4'd0, 4'd2, 4'd1},
    '{1'b1, 1'b1, 2'd3, 2'd3, 2'd1, 2'd2, 4'd0, 4'd4, 4'd2},
    '{1'b0, 1'b0, 2'd2, 2'd1, 2'd0, 2'd0, 4'd3, 4'd6, 4'd3},
    '{1'b1, 1'b1, 2'd0, 2'd0, 2'd2, 2'd3, 4'd1, 4'd4, 4'd1},
    '{1'b0, 1'b1, 2'd1, 2'd2, 2'd3, 2'd0, 4'd2, 4'd6, 4'd2},
    '{1'b1, 1'b0, 2'd1, 2'd1, 2'd0, 2'd1, 4'd0, 4'd5, 4'd3}
  };

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [0:0] req_drive;
  logic       req_write;
  logic       iordy;
  logic [3:0] sample_codes;
  logic [3:0] recov_codes;
  logic       rd_strobe_n, wr_strobe_n, busy, done;
  int         n_tests;
  int         n_fail;

  wire any_low = !rd_strobe_n || !wr_strobe_n;

  ide_pio_timer dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_drive    (req_drive),
    .req_write    (req_write),
    .iordy        (iordy),
    .sample_codes (sample_codes),
    .recov_codes  (recov_codes),
    .rd_strobe_n  (rd_strobe_n),
    .wr_strobe_n  (wr_strobe_n),
    .busy         (busy),
    .done         (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int idx,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s vec%0d actual=%0d expected=%0d", req, idx, act, exp);
    end
  endtask

  task automatic wait_strobe_low();
    int spin = 0;
    do begin
      @(negedge clk);
      spin++;
    end while (!any_low && spin < 50);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int width;
    int gap;
    bit bad_dir;
    @(negedge clk);
    sample_codes = {v.s1, v.s0};
    recov_codes  = {v.r1, v.r0};
    req_drive    = v.drive;
    req_write    = v.write;
    iordy        = (v.waits == 0);
    req_valid    = 1'b1;
    wait_strobe_low();
    width   = 1;
    bad_dir = 1'b0;
    while (any_low && width < 40) begin
      if (v.write ? (!rd_strobe_n || wr_strobe_n) : (!wr_strobe_n || rd_strobe_n)) bad_dir = 1'b1;
      if (width == int'(v.exp_w)) iordy = 1'b1;
      @(negedge clk);
      if (any_low) width++;
    end
    // R2 / R7: direction picks the strobe
    check(!bad_dir, "R2", idx, int'(bad_dir), 0);
    // R3 / R4 / R7: width from the addressed drive's code plus ready-low clocks
    check(width == int'(v.exp_w), "R3", idx, width, int'(v.exp_w));
    // R5: completion pulse follows the ready-high sample
    check(done == 1'b1, "R5", idx, int'(done), 1);
    // R6: busy held through recovery
    check(busy == (v.exp_gap > 1), "R6", idx, int'(busy), int'(v.exp_gap > 1));
    gap = 1;
    @(negedge clk);
    check(done == 1'b0, "R5", idx, int'(done), 0);
    while (!any_low && gap < 40) begin
      gap++;
      @(negedge clk);
    end
    // R6 / R8: request held throughout is only taken once recovery ends
    check(gap == int'(v.exp_gap), "R6", idx, gap, int'(v.exp_gap));
    req_valid = 1'b0;
    gap = 0;
    while ((busy || any_low) && gap < 60) begin
      @(negedge clk);
      gap++;
    end
    check(!busy && !any_low, "R8", idx, int'(busy), 0);
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_tests, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int width;
    bit bad;
    rst_n        = 1'b0;
    req_valid    = 1'b0;
    req_drive    = '0;
    req_write    = 1'b0;
    iordy        = 1'b1;
    sample_codes = '0;
    recov_codes  = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rd_strobe_n && wr_strobe_n, "R1", -1, int'(rd_strobe_n && wr_strobe_n), 1);
    check(!busy && !done, "R1", -1, int'(busy || done), 0);
    rst_n = 1'b1;
    bad = 1'b0;
    for (int k = 0; k < 8; k++) begin
      iordy = k[0];
      @(negedge clk);
      if (any_low || busy || done) bad = 1'b1;
    end
    // R1: no request, ready toggling -> stays quiet
    check(!bad, "R1", -1, int'(bad), 0);
    iordy = 1'b1;

    for (int i = 0; i < 8; i++) run_vec(VECS[i], i);

    // R9: inputs changed mid-cycle do not affect the accepted cycle
    @(negedge clk);
    sample_codes = 4'b1100;
    recov_codes  = 4'b1100;
    req_drive    = 1'b0;
    req_write    = 1'b0;
    iordy        = 1'b1;
    req_valid    = 1'b1;
    wait_strobe_low();
    req_drive    = 1'b1;
    req_write    = 1'b1;
    sample_codes = 4'b1111;
    recov_codes  = 4'b1111;
    width = 1;
    bad = 1'b0;
    while (any_low && width < 40) begin
      if (!wr_strobe_n) bad = 1'b1;
      @(negedge clk);
      if (any_low) width++;
    end
    check(width == 5, "R9", -1, width, 5);
    check(!bad, "R9", -1, int'(bad), 0);
    width = 0;
    while (!any_low && width < 40) begin
      width++;
      @(negedge clk);
    end
    check(width == 4, "R9", -1, width, 4);
    req_valid = 1'b0;
    // Second cycle uses the new drive and direction: write strobe, 2 clocks
    check(!wr_strobe_n && rd_strobe_n, "R7", -1, int'(wr_strobe_n), 0);
    width = 1;
    while (any_low && width < 40) begin
      @(negedge clk);
      if (any_low) width++;
    end
    check(width == 2, "R7", -1, width, 2);
    repeat (3) @(negedge clk);

    // R1: reset asserted in the middle of a strobe
    sample_codes = '0;
    recov_codes  = '0;
    req_drive    = 1'b0;
    req_write    = 1'b1;
    iordy        = 1'b0;
    req_valid    = 1'b1;
    wait_strobe_low();
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(rd_strobe_n && wr_strobe_n && !busy, "R1", -1, int'(wr_strobe_n), 1);
    @(negedge clk);
    rst_n = 1'b1;
    iordy = 1'b1;
    repeat (4) @(negedge clk);
    check(!any_low && !busy && !done, "R1", -1, int'(busy), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule